// File: doc/BRIEF.md
# Packed Single-Precision Compare Unit

This block compares four pairs of IEEE-754 single-precision numbers, one pair per 32-bit lane of two 128-bit operands. A 3-bit predicate code chooses the relation. Each lane of the result becomes an all-ones word when the relation holds and an all-zeros word when it does not. The result is a mask that later logic can use for bitwise selects.

A scalar/packed flag picks the mode. In packed mode all four lanes are compared. In scalar mode only lane 0 is compared, and lanes 1 to 3 of the output repeat the first operand unchanged. An input strobe marks a valid request. The mask and an output-valid flag are registered, so they appear on the clock edge after the strobe.

Top module: `fcmp4_top`

## Requirements
- R1: Predicate code (srcA relation srcB) selects: 0 equal, 1 less than, 2 less or equal, 3 unordered, 4 not equal, 5 not less than, 6 not less or equal, 7 ordered. A true lane is 32'hFFFFFFFF and a false lane is 32'h00000000.
- R2: A value is NaN when exponent bits [30:23] are all ones and mantissa bits [22:0] are nonzero. Code 3 is true when either input is NaN. Code 7 is true only when neither input is NaN.
- R3: When either input of a lane is NaN, codes 0, 1 and 2 give false and codes 4, 5 and 6 give true.
- R4: For ordered inputs, code 5 acts as greater-or-equal and code 6 acts as greater-than.
- R5: Positive zero and negative zero compare as equal. Infinities are ordered and compare by sign, and they rank above or below every finite value.
- R6: Negative finite values order by magnitude in reverse. A negative value with the larger magnitude is the lesser value.
- R7: In scalar mode (isScalar=1) only lane 0 (bits [31:0]) carries the compare result. Bits [127:32] of the output equal bits [127:32] of srcA.
- R8: resValid is high exactly one clock after inValid is sampled high, and the mask of that request appears in the same cycle. After reset, resValid is 0 and resMask is 0.
- R9: resMask holds its value in cycles when no request was issued in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| isScalar | input | 1 | 1 = compare lane 0 only, 0 = compare all four lanes |
| predCode | input | 3 | Predicate select |
| srcA | input | 128 | First operand, four singles |
| srcB | input | 128 | Second operand, four singles |
| resValid | output | 1 | Result valid |
| resMask | output | 128 | Per-lane mask result |

## Verification
Every result is due exactly one clock after its strobe. The driver applies inputs away from the clock edge and pushes the expected mask into a queue. The monitor samples at the falling edge after each rising edge. Whenever resValid is high it pops one entry and compares the whole 128-bit mask, so a result that arrives a cycle late or early shows up as a mismatch or as leftover queue entries. Idle cycles are also checked: the mask must hold its value in them. The expected masks come from a separate model in the bench that converts each float to a sortable integer key.

// File: rtl/fcmp4_pkg.sv
package fcmp4_pkg;
  localparam int LANES = 4;
  localparam int LANE_W = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int VEC_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    PRED_EQ   = 3'd0,
    PRED_LT   = 3'd1,
    PRED_LE   = 3'd2,
    PRED_UNO  = 3'd3,
    PRED_NE   = 3'd4,
    PRED_NLT  = 3'd5,
    PRED_NLE  = 3'd6,
    PRED_ORD  = 3'd7
  } predE;

  typedef struct packed {
    logic capture;
    logic scalarSel;
    logic [2:0] pred;
  } ctrlS;
endpackage

// File: rtl/fcmp4_ctrl.sv
module fcmp4_ctrl
  import fcmp4_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       isScalar,
  input  logic [2:0] predCode,
  output ctrlS       ctrl,
  output logic       resValid
);
  always_comb begin
    ctrl.capture   = inValid;
    ctrl.scalarSel = isScalar;
    ctrl.pred      = predCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end
endmodule

// File: rtl/fcmp4_lane.sv
module fcmp4_lane
  import fcmp4_pkg::*;
#(
  parameter int W = LANE_W,
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   pred,
  output logic         hit
);
  logic aNan, bNan, unord, aZero, bZero;
  logic eq, lt;

  always_comb begin
    aNan  = (&a[W-2 -: EW]) && (|a[MW-1:0]);
    bNan  = (&b[W-2 -: EW]) && (|b[MW-1:0]);
    unord = aNan || bNan;
    aZero = ~|a[W-2:0];
    bZero = ~|b[W-2:0];
    eq = (a == b) || (aZero && bZero);
    // sign-magnitude ordering
    if (eq) lt = 1'b0;
    else if (a[W-1] != b[W-1]) lt = a[W-1];
    else if (a[W-1]) lt = a[W-2:0] > b[W-2:0];
    else lt = a[W-2:0] < b[W-2:0];

    unique case (predE'(pred))
      PRED_EQ:  hit = !unord && eq;
      PRED_LT:  hit = !unord && lt;
      PRED_LE:  hit = !unord && (lt || eq);
      PRED_UNO: hit = unord;
      PRED_NE:  hit = unord || !eq;
      PRED_NLT: hit = unord || !lt;
      PRED_NLE: hit = unord || !(lt || eq);
      default:  hit = !unord;
    endcase
  end
endmodule

// File: rtl/fcmp4_dp.sv
module fcmp4_dp
  import fcmp4_pkg::*;
#(
  parameter int N = LANES,
  parameter int W = LANE_W,
  localparam int VW = N * W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlS          ctrl,
  input  logic [VW-1:0] srcA,
  input  logic [VW-1:0] srcB,
  output logic [VW-1:0] resMask
);
  logic [VW-1:0] nextMask;

  for (genvar g = 0; g < N; g++) begin : gLane
    logic hit;
    fcmp4_lane #(.W(W)) u_lane (
      .a(srcA[g*W +: W]), .b(srcB[g*W +: W]), .pred(ctrl.pred), .hit(hit)
    );
    if (g == 0) begin : gLow
      assign nextMask[W-1:0] = {W{hit}};
    end else begin : gHigh
      assign nextMask[g*W +: W] = ctrl.scalarSel ? srcA[g*W +: W] : {W{hit}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) resMask <= '0;
    else if (ctrl.capture) resMask <= nextMask;
  end
endmodule

// File: rtl/fcmp4_top.sv
module fcmp4_top
  import fcmp4_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               isScalar,
  input  logic [2:0]         predCode,
  input  logic [VEC_W-1:0]   srcA,
  input  logic [VEC_W-1:0]   srcB,
  output logic               resValid,
  output logic [VEC_W-1:0]   resMask
);
  ctrlS ctrl;

  fcmp4_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isScalar(isScalar),
    .predCode(predCode), .ctrl(ctrl), .resValid(resValid)
  );

  fcmp4_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .resMask(resMask)
  );
endmodule

// File: rtl/fcmp4_chk.sv
module fcmp4_chk
  import fcmp4_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             isScalar,
  input logic [2:0]       predCode,
  input logic [VEC_W-1:0] srcA,
  input logic             resValid,
  input logic [VEC_W-1:0] resMask
);
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);
  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(resMask));
  // R7
  scalar_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isScalar) |=> resMask[VEC_W-1:LANE_W] == $past(srcA[VEC_W-1:LANE_W]));
  // R1
  lane_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isScalar) |=> (resMask[31:0] == '0 || resMask[31:0] == '1)
      && (resMask[127:96] == '0 || resMask[127:96] == '1));
  // R2
  uno_ord_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isScalar && predCode == 3'd3) |=> resMask[31:0] == '0 || resMask[31:0] == '1);
endmodule

bind fcmp4_top fcmp4_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .isScalar(isScalar),
  .predCode(predCode), .srcA(srcA), .resValid(resValid), .resMask(resMask)
);

// File: tb/fcmp4_top_tb.sv
module fcmp4_top_tb;
  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0, isScalar = 0;
  logic [2:0] predCode = 0;
  logic [127:0] srcA = 0, srcB = 0;
  logic resValid;
  logic [127:0] resMask;
  int checks = 0, fails = 0;
  logic [127:0] expQ[$];
  string tagQ[$];
  logic [127:0] lastMask;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  fcmp4_top u_dut (.clk, .rstN, .inValid, .isScalar, .predCode, .srcA, .srcB,
                   .resValid, .resMask);

  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000;
  localparam logic [31:0] M1 = 32'hBF800000, M2 = 32'hC0000000;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'hFF800001;

  function automatic bit isNan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  // map to an integer key that sorts like the float
  function automatic longint key(logic [31:0] v);
    longint m = longint'(v[30:0]);
    if (m == 0) return 0;
    return v[31] ? -m : m;
  endfunction
  function automatic bit model(logic [31:0] a, logic [31:0] b, logic [2:0] p);
    bit u = isNan(a) || isNan(b);
    longint ka = key(a), kb = key(b);
    case (p)
      0: return !u && ka == kb;
      1: return !u && ka < kb;
      2: return !u && ka <= kb;
      3: return u;
      4: return u || ka != kb;
      5: return u || ka >= kb;
      6: return u || ka > kb;
      default: return !u;
    endcase
  endfunction

  task automatic send(input bit sc, input logic [2:0] p,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
    logic [127:0] e;
    for (int l = 0; l < 4; l++)
      e[l*32 +: 32] = (sc && l > 0) ? a[l*32 +: 32] : {32{model(a[l*32 +: 32], b[l*32 +: 32], p)}};
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    inValid = 1; isScalar = sc; predCode = p; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 0; srcA = $urandom; srcB = '1;
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: samples at negedge, after the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (resValid) begin
          if (expQ.size() == 0) check("R8 unexpected valid", 128'd1, 128'd0);
          else check(tagQ.pop_front(), resMask, expQ.pop_front());
        end else begin
          check("R9 hold", resMask, lastMask);
        end
        lastMask = resMask;
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", {127'd0, resValid}, 128'd0);
    check("R8 reset mask", resMask, 128'd0);
    lastMask = resMask;
    rstN = 1;
    // R1 basic ordering, all predicates
    for (int p = 0; p < 8; p++)
      send(0, p[2:0], {ONE, TWO, ONE, M1}, {ONE, ONE, TWO, ONE}, "R1 predicates");
    // R2 R3 NaN handling
    for (int p = 0; p < 8; p++)
      send(0, p[2:0], {QNAN, ONE, SNAN, PINF}, {ONE, QNAN, SNAN, PINF}, "R2 R3 nan");
    // R4 not-less predicates on ordered inputs
    send(0, 3'd5, {ONE, TWO, M1, PZ}, {ONE, ONE, ONE, PZ}, "R4 nlt");
    send(0, 3'd6, {ONE, TWO, M1, PZ}, {ONE, ONE, ONE, PZ}, "R4 nle");
    // R5 zeros and infinities
    send(0, 3'd0, {PZ, NZ, PINF, NINF}, {NZ, PZ, PINF, NINF}, "R5 zero eq");
    send(0, 3'd1, {NINF, M2, PINF, ONE}, {M2, PINF, 32'h7F7FFFFF, PINF}, "R5 inf lt");
    send(0, 3'd2, {NZ, PZ, NINF, PINF}, {PZ, NZ, NINF, NINF}, "R5 le");
    // R6 negative ordering
    send(0, 3'd1, {M2, M1, M1, 32'h80000001}, {M1, M2, M1, NZ}, "R6 neg lt");
    // R7 scalar mode
    send(1, 3'd1, {32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F, ONE}, {ONE, ONE, ONE, TWO}, "R7 scalar lt");
    send(1, 3'd3, {QNAN, QNAN, QNAN, ONE}, {QNAN, QNAN, QNAN, ONE}, "R7 scalar uno");
    // R8 back-to-back requests
    expQ.push_back({4{32'hFFFFFFFF}}); tagQ.push_back("R8 b2b first");
    expQ.push_back({4{32'h00000000}}); tagQ.push_back("R8 b2b second");
    @(negedge clk);
    inValid = 1; isScalar = 0; predCode = 3'd7; srcA = {4{ONE}}; srcB = {4{TWO}};
    @(negedge clk);
    predCode = 3'd3;
    @(negedge clk);
    inValid = 0;
    repeat (4) @(negedge clk);
    check("R8 queue drained", 128'(expQ.size()), 128'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule